// File: doc/BRIEF.md
# Clock Ratio Detect and Power-Down Controller

This block sequences the startup of an audio DAC core. After reset the DAC is held in power-down: the interpolation filter and delta-sigma modulator stay in reset, and the analog reference and switched-capacitor filter stay powered off. All of this is represented here by one power-down output. The block runs on the master clock. It synchronizes the frame (left/right) clock into that domain and waits until the frame clock is clearly active.

Once both clocks are running, the block counts master-clock cycles across one full frame period. That count becomes the stored clock ratio, and the block then releases power-down. While running, it measures every frame period again. If a period differs from the stored ratio, or the frame clock stops, the block falls back to power-down, clears the ratio and starts the whole detection sequence again.

A period is always measured from one rising edge of the frame clock to the next. The duty cycle therefore has no effect on the result. The ratio is held in a 10-bit field, so a period longer than 1023 master-clock cycles is a ratio error.

Top module: `crd_ratio_ctrl`

## Requirements
- R1: An active-low reset forces, asynchronously, pwr_dn=1, ratio_ok=0 and ratio=0. Internal release is synchronized over two master-clock edges.
- R2: pwr_dn is 1 (filter and modulator held in reset) in every phase other than running. While pwr_dn is 1, ratio reads 0 and ratio_ok is 0.
- R3: With the frame clock idle, or with only one rising edge and no second one within 4096 master-clock cycles, the block stays powered down.
- R4: After two rising edges show that the frame clock is present, the next rising edge opens a measurement window and the one after closes it. At that closing edge, ratio takes the number of master-clock cycles between the two edges, and ratio_ok rises while pwr_dn falls.
- R5: While running, a rising-to-rising period that differs from the stored ratio, longer or shorter, returns the block to power-down with ratio cleared. A later steady frame clock is learned again through the full sequence.
- R6: While running, if no frame-clock rising edge is seen for 4096 master-clock cycles, the block returns to power-down. A gap shorter than that keeps it running.
- R7: A measured period of 1023 cycles is accepted. A period of 1024 or more is a ratio error: the block never reaches running with such a period.
- R8: Only the rising-to-rising interval counts. An asymmetric frame clock (for example 100 cycles high and 101 low) yields ratio 201.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, asynchronous to the logic, synchronized inside |
| pwr_dn | output | 1 | 1 = DAC core in power-down, filter and modulator held in reset |
| ratio | output | CNT_W (10) | Stored master-clock cycles per frame period; 0 when not running |
| ratio_ok | output | 1 | 1 = ratio measured and being tracked, DAC running |

## Verification
The bench targets the boundary between an accepted ratio of 1023 and a rejected one of 1024. A design with an off-by-one counter would either run with a truncated ratio or reject the largest legal ratio. It shortens a single frame period by one cycle while running and swaps between frame rates, which exposes a design that checks only the first period or does not clear and relearn the ratio. It holds the frame clock static just below and just past the 4096-cycle loss window, which catches a wrong timeout length. It also drives an asymmetric duty cycle, which a design timing half periods would mismeasure.

// File: rtl/crd_pkg.sv
package crd_pkg;
  typedef enum logic [1:0] {
    ST_PD   = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2,
    ST_RUN  = 2'd3
  } crd_state_e;
endpackage

// File: rtl/crd_reset_sync.sv
module crd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/crd_edge_sync.sv
module crd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int TOTAL = STAGES + 1;
  logic [TOTAL-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[TOTAL-2:0], din};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/crd_period_cnt.sv
module crd_period_cnt #(
  parameter int CNT_W   = 10,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [CNT_W-1:0] period,
  output logic             over,
  output logic             lost
);
  localparam int             GAP_W    = $clog2(TIMEOUT) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(TIMEOUT - 1);
  localparam logic [GAP_W-1:0] OVER_LIM = GAP_W'((1 << CNT_W) - 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;

  always_comb begin
    gap_en = rise || (gap_q < GAP_MAX);
    gap_d  = rise ? '0 : gap_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign over   = (gap_q >= OVER_LIM);
  assign period = gap_q[CNT_W-1:0] + CNT_W'(1);
  assign lost   = !rise && (gap_q >= GAP_MAX);
endmodule

// File: rtl/crd_seq_fsm.sv
module crd_seq_fsm
  import crd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             lost,
  input  logic             over,
  input  logic [CNT_W-1:0] period,
  output crd_state_e       state,
  output logic [CNT_W-1:0] ratio,
  output logic             pwr_dn,
  output logic             ratio_ok
);
  crd_state_e       st_q, st_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;
  logic             capture;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    capture = 1'b0;
    unique case (st_q)
      ST_PD: begin
        if (rise) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rise) begin
          st_d    = ST_MEAS;
          armed_d = 1'b0;
        end else if (lost) begin
          st_d = ST_PD;
        end
      end
      ST_MEAS: begin
        if (lost) begin
          st_d = ST_PD;
        end else if (rise && !armed_q) begin
          armed_d = 1'b1;
        end else if (rise) begin
          if (over) begin
            st_d = ST_PD;
          end else begin
            st_d    = ST_RUN;
            capture = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (lost) st_d = ST_PD;
        else if (rise && (over || period != ratio_q)) st_d = ST_PD;
      end
      default: st_d = ST_PD;
    endcase
  end

  always_comb begin
    if (capture)             ratio_d = period;
    else if (st_d == ST_RUN) ratio_d = ratio_q;
    else                     ratio_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PD;
      armed_q <= 1'b0;
      ratio_q <= '0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      ratio_q <= ratio_d;
    end
  end

  assign state    = st_q;
  assign ratio    = ratio_q;
  assign pwr_dn   = (st_q != ST_RUN);
  assign ratio_ok = (st_q == ST_RUN);
endmodule

// File: rtl/crd_ratio_ctrl.sv
module crd_ratio_ctrl
  import crd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TIMEOUT     = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             lrck,
  output logic             pwr_dn,
  output logic [CNT_W-1:0] ratio,
  output logic             ratio_ok
);
  logic             srst_n;
  logic             rise_w;
  logic             lost_w;
  logic             over_w;
  logic [CNT_W-1:0] period_w;
  crd_state_e       state_w;

  crd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (mclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  crd_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (mclk),
    .rst_n (srst_n),
    .din   (lrck),
    .rise  (rise_w)
  );

  crd_period_cnt #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cnt (
    .clk    (mclk),
    .rst_n  (srst_n),
    .rise   (rise_w),
    .period (period_w),
    .over   (over_w),
    .lost   (lost_w)
  );

  crd_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (mclk),
    .rst_n    (srst_n),
    .rise     (rise_w),
    .lost     (lost_w),
    .over     (over_w),
    .period   (period_w),
    .state    (state_w),
    .ratio    (ratio),
    .pwr_dn   (pwr_dn),
    .ratio_ok (ratio_ok)
  );
endmodule

// File: rtl/crd_checker.sv
module crd_checker
  import crd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic             ratio_ok,
  input logic [CNT_W-1:0] ratio,
  input logic             rise,
  input logic             lost,
  input logic             over,
  input logic [CNT_W-1:0] period,
  input crd_state_e       state
);
  assert_pd_clears_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (ratio == '0));

  assert_idle_holds_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD) |=> pwr_dn);

  assert_run_entry_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn) |-> ($past(rise) && ratio != '0));

  assert_ratio_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_ok && $past(ratio_ok)) |-> (ratio == $past(ratio)));

  assert_mismatch_exits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_ok && rise && period != ratio) |=> pwr_dn);

  assert_loss_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_ok && lost) |=> pwr_dn);

  assert_overlong_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && over) |=> pwr_dn);
endmodule

bind crd_ratio_ctrl crd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (mclk),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .ratio_ok (ratio_ok),
  .ratio    (ratio),
  .rise     (rise_w),
  .lost     (lost_w),
  .over     (over_w),
  .period   (period_w),
  .state    (state_w)
);

// File: tb/tb_crd_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_crd_ratio_ctrl;
  localparam int TO = 4096;

  logic       mclk;
  logic       rst_n;
  logic       lrck;
  logic       pwr_dn;
  logic [9:0] ratio;
  logic       ratio_ok;

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    cmp_on = 0;
  bit    done = 0;

  // behavioural reference state
  int m_st, m_armed, m_gap, m_ratio, rsync;
  bit h1, h2, h3;

  crd_ratio_ctrl dut (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck),
    .pwr_dn(pwr_dn), .ratio(ratio), .ratio_ok(ratio_ok)
  );

  initial mclk = 0;
  always #4 mclk = ~mclk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference: states 0=off 1=waiting 2=measuring 3=running
  always @(posedge mclk) begin
    if (!rst_n) begin
      rsync = 0; h1 = 0; h2 = 0; h3 = 0;
      m_st = 0; m_armed = 0; m_gap = 0; m_ratio = 0;
    end else if (rsync < 2) begin
      rsync++;
    end else begin
      bit rise, lost, over;
      int per;
      rise = h2 && !h3;
      lost = !rise && (m_gap >= TO - 1);
      per  = m_gap + 1;
      over = (m_gap >= 1023);
      case (m_st)
        0: if (rise) m_st = 1;
        1: if (rise) begin m_st = 2; m_armed = 0; end
           else if (lost) m_st = 0;
        2: if (lost) m_st = 0;
           else if (rise && !m_armed) m_armed = 1;
           else if (rise) begin
             if (over) m_st = 0;
             else begin m_st = 3; m_ratio = per; end
           end
        default: if (lost || (rise && (over || per != m_ratio))) m_st = 0;
      endcase
      if (m_st != 3) m_ratio = 0;
      if (rise) m_gap = 0;
      else if (m_gap < TO - 1) m_gap++;
      h3 = h2; h2 = h1; h1 = lrck;
    end
  end

  always @(negedge mclk) begin
    if (cmp_on && !done) begin
      int e_pd;
      e_pd = (!rst_n || m_st != 3) ? 1 : 0;
      chk("R2", {"pwr_dn in phase ", phase}, int'(pwr_dn), e_pd);
      chk(phase, "ratio_ok", int'(ratio_ok), 1 - e_pd);
      chk(phase, "ratio", int'(ratio), (e_pd == 1) ? 0 : m_ratio);
    end
  end

  task automatic drive(int hi, int lo, int periods);
    for (int p = 0; p < periods; p++) begin
      lrck = 0;
      repeat (lo) @(negedge mclk);
      lrck = 1;
      repeat (hi) @(negedge mclk);
    end
  endtask

  task automatic hold(bit lvl, int n);
    lrck = lvl;
    repeat (n) @(negedge mclk);
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    lrck  = 0;
    repeat (5) @(negedge mclk);
    cmp_on = 1;
    phase = "R1";
    chk("R1", "pwr_dn in reset", int'(pwr_dn), 1);
    chk("R1", "ratio_ok in reset", int'(ratio_ok), 0);
    chk("R1", "ratio in reset", int'(ratio), 0);
    #1 rst_n = 1;
    @(negedge mclk);

    // R3: idle clock, then a lone edge
    phase = "R3";
    hold(0, 5000);
    chk("R3", "pwr_dn with idle frame clock", int'(pwr_dn), 1);
    hold(1, 10);
    hold(0, 5000);
    chk("R3", "pwr_dn after lone edge", int'(pwr_dn), 1);

    // R4: learn 64
    phase = "R4";
    drive(32, 32, 8);
    chk("R4", "ratio_ok at 64", int'(ratio_ok), 1);
    chk("R4", "ratio at 64", int'(ratio), 64);

    // R5: rate change, then relearn
    phase = "R5";
    drive(64, 64, 3);
    chk("R5", "pwr_dn after rate change", int'(pwr_dn), 1);
    chk("R5", "ratio cleared after rate change", int'(ratio), 0);
    drive(64, 64, 4);
    chk("R5", "ratio relearned at 128", int'(ratio), 128);

    // R8: asymmetric duty
    phase = "R8";
    drive(100, 101, 8);
    chk("R8", "ratio asymmetric", int'(ratio), 201);

    // R7: largest legal and first illegal ratio
    phase = "R7";
    drive(511, 512, 8);
    chk("R7", "ratio at 1023", int'(ratio), 1023);
    chk("R7", "ratio_ok at 1023", int'(ratio_ok), 1);
    drive(512, 512, 8);
    chk("R7", "pwr_dn at 1024", int'(pwr_dn), 1);

    // R6: loss of frame clock
    phase = "R6";
    drive(32, 32, 8);
    hold(1, 4000);
    chk("R6", "ratio_ok before timeout", int'(ratio_ok), 1);
    hold(1, 200);
    chk("R6", "pwr_dn after timeout", int'(pwr_dn), 1);

    // R5: one short period
    phase = "R5";
    drive(32, 32, 8);
    chk("R5", "ratio_ok before glitch", int'(ratio_ok), 1);
    drive(31, 32, 1);
    drive(32, 32, 1);
    chk("R5", "pwr_dn after short period", int'(pwr_dn), 1);
    drive(32, 32, 6);

    // R1: asynchronous reset while running
    phase = "R1";
    chk("R1", "ratio_ok before reset", int'(ratio_ok), 1);
    #1 rst_n = 0;
    #1;
    chk("R1", "pwr_dn immediately on reset", int'(pwr_dn), 1);
    chk("R1", "ratio immediately on reset", int'(ratio), 0);
    @(negedge mclk);
    #1 rst_n = 1;
    @(negedge mclk);
    phase = "R4";
    drive(40, 40, 8);
    chk("R4", "ratio after reset relearn", int'(ratio), 80);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule